// File: doc/BRIEF.md
# Grouped Rotating-Priority DMA Channel Arbiter

This block chooses one DMA channel per transfer from twelve requesters: ten peripheral channels (five receive, five transmit) and two memory-to-memory channels. The choice is made inside the DMA engine first. The winner's grant is then presented together with a single bus request toward the system bus arbiter, such as an AHB arbiter. Once that outer arbiter grants the bus, the winner is locked in place until the transfer-done strobe arrives.

The base ranking is built from the two channel groups. A control input sets which group comes first. A rotating pointer, kept as a position in the base ranking, sets where each search starts. After every completed transfer the pointer moves one place past the channel just served. Bus data movement is not part of this block.

Top module: `grouped_dma_arbiter`

## Requirements
- R1: After reset, or while `rst_ni` is low, `gnt_o` is all zero and `bus_req_o` is low, and the rotation pointer is at position 0.
- R2: A request present at a clock edge, with no bus ownership in progress, yields a one-hot `gnt_o` on a requesting channel after that edge, and `bus_req_o` is high whenever `gnt_o` is non-zero. Channel index c is bit c of `req_i`/`gnt_o`: bits 0 to 9 are peripheral channels 0 to 9, and bits 10 and 11 are memory-to-memory channels 0 and 1.
- R3: With `mem_first_i` = 0 the base ranking is positions 0 to 11 = channels 0 to 11, so peripheral channels come before memory-to-memory channels.
- R4: With `mem_first_i` = 1 the base ranking is channel 10, channel 11, then channels 0 to 9. Channel c therefore sits at position (c+2) mod 12.
- R5: The search starts at the pointer position and wraps past 11 to 0. When a granted transfer completes, the pointer becomes the winner's position plus one, modulo 12.
- R6: Before the outer bus grant, the grant is re-evaluated at every edge and follows the current requests. It drops to zero when nothing requests. In this phase `xfer_done_i` has no effect.
- R7: If `bus_gnt_i` is high at an edge while `gnt_o` is non-zero, the grant freezes. From then until `xfer_done_i`, changes to `req_i` and `mem_first_i` do not alter `gnt_o`.
- R8: `xfer_done_i` during frozen ownership clears `gnt_o` and `bus_req_o` at the next edge. Arbitration resumes at the edge after that.
- R9: With no request and no ownership, `gnt_o` stays zero and the pointer keeps its value.
- R10: A change of `mem_first_i` is applied at the next arbitration decision after ownership ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 12 | Per-channel transfer request |
| mem_first_i | input | 1 | Group order select (1: memory-to-memory group first) |
| bus_gnt_i | input | 1 | Grant from the outer bus arbiter |
| xfer_done_i | input | 1 | Current transfer finished |
| gnt_o | output | 12 | One-hot channel grant |
| bus_req_o | output | 1 | Bus request toward the outer arbiter |

## Verification
The hardest state to reach is a rotation pointer that wraps in the middle of the ranking while the group order has just been switched. Whether the pointer's numeric position maps to the right channel then depends on the mapping that applies at the new decision, not the one used for the previous winner. The stimulus table reaches this state by chaining complete grant/done rounds. It serves channels 11, 10 and 9 so that the pointer lands on positions 0, 10 and 11, and it toggles the order select between rounds. Directed sequences then switch the select during frozen ownership and drop requests before the outer grant, and they confirm from the next winner that the pointer did not move.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ST_ARB = 1'b0,
    ST_OWN = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_order_map.sv
// Permutes channel requests into base-ranking positions.
module arb_order_map #(
  parameter int N  = 12,
  parameter int NP = 10
) (
  input  logic         mem_first_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] ord_o
);
  for (genvar p = 0; p < N; p++) begin : g_pos
    localparam int ChMem = (p + NP) % N;
    assign ord_o[p] = mem_first_i ? req_i[ChMem] : req_i[p];
  end
endmodule

// File: rtl/arb_rr_pick.sv
// First set bit at or after ptr_i, wrapping.
module arb_rr_pick #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] ptr_i,
  output logic          vld_o,
  output logic [IW-1:0] pos_o
);
  localparam logic [IW:0] NW = (IW+1)'(N);

  always_comb begin
    logic [IW:0] p;
    vld_o = 1'b0;
    pos_o = '0;
    for (int i = 0; i < N; i++) begin
      p = {1'b0, ptr_i} + (IW+1)'(i);
      if (p >= NW) p = p - NW;
      if (!vld_o && vec_i[p[IW-1:0]]) begin
        vld_o = 1'b1;
        pos_o = p[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/grouped_dma_arbiter.sv
module grouped_dma_arbiter #(
  parameter int NUM_PERIPH = 10,
  parameter int NUM_MEM    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PERIPH+NUM_MEM-1:0] req_i,
  input  logic                          mem_first_i,
  input  logic                          bus_gnt_i,
  input  logic                          xfer_done_i,
  output logic [NUM_PERIPH+NUM_MEM-1:0] gnt_o,
  output logic                          bus_req_o
);
  import arb_pkg::*;

  localparam int N  = NUM_PERIPH + NUM_MEM;
  localparam int IW = $clog2(N);
  localparam logic [IW:0] NW  = (IW+1)'(N);
  localparam logic [IW:0] NPW = (IW+1)'(NUM_PERIPH);

  arb_state_e    st_q;
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] pos_q, ptr_q;
  logic [N-1:0]  ord_req;
  logic          pick_vld;
  logic [IW-1:0] pick_pos;
  logic [IW-1:0] pick_ch;
  logic [N-1:0]  pick_oh;

  arb_order_map #(.N(N), .NP(NUM_PERIPH)) u_map (
    .mem_first_i (mem_first_i),
    .req_i       (req_i),
    .ord_o       (ord_req)
  );

  arb_rr_pick #(.N(N), .IW(IW)) u_pick (
    .vec_i (ord_req),
    .ptr_i (ptr_q),
    .vld_o (pick_vld),
    .pos_o (pick_pos)
  );

  // position -> channel index under the current order
  always_comb begin
    logic [IW:0] t;
    t = {1'b0, pick_pos};
    if (mem_first_i) begin
      t = t + NPW;
      if (t >= NW) t = t - NW;
    end
    pick_ch = t[IW-1:0];
    pick_oh = pick_vld ? ({{(N-1){1'b0}}, 1'b1} << pick_ch) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ARB;
      gnt_q <= '0;
      pos_q <= '0;
      ptr_q <= '0;
    end else begin
      unique case (st_q)
        ST_ARB: begin
          if (bus_gnt_i && (|gnt_q)) begin
            st_q <= ST_OWN;
          end else begin
            gnt_q <= pick_oh;
            pos_q <= pick_pos;
          end
        end
        ST_OWN: begin
          if (xfer_done_i) begin
            st_q  <= ST_ARB;
            gnt_q <= '0;
            ptr_q <= (pos_q == IW'(N-1)) ? '0 : pos_q + 1'b1;
          end
        end
        default: st_q <= ST_ARB;
      endcase
    end
  end

  assign gnt_o     = gnt_q;
  assign bus_req_o = |gnt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic         bus_gnt_i,
  input logic         xfer_done_i,
  input logic [N-1:0] gnt_o,
  input logic         bus_req_o
);
  logic owned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owned_q <= 1'b0;
    else if (owned_q && xfer_done_i) owned_q <= 1'b0;
    else if (!owned_q && bus_gnt_i && (|gnt_o)) owned_q <= 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_bus_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> bus_req_o);

  p_new_gnt_requested_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != $past(gnt_o)) && (|gnt_o)) |-> ((gnt_o & $past(req_i)) != '0));

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned_q && !xfer_done_i) |=> $stable(gnt_o));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned_q && xfer_done_i) |=> (gnt_o == '0 && !bus_req_o));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owned_q && req_i == '0) |=> (gnt_o == '0));
endmodule

bind grouped_dma_arbiter arb_checker #(.N(N)) u_arb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .bus_gnt_i   (bus_gnt_i),
  .xfer_done_i (xfer_done_i),
  .gnt_o       (gnt_o),
  .bus_req_o   (bus_req_o)
);

// File: tb/grouped_dma_arbiter_bench.sv
`timescale 1ns/1ps
module grouped_dma_arbiter_bench;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         mem_first_i = 1'b0;
  logic         bus_gnt_i = 1'b0;
  logic         xfer_done_i = 1'b0;
  logic [N-1:0] gnt_o;
  logic         bus_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  grouped_dma_arbiter u_grouped_dma_arbiter (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mem_first_i (mem_first_i),
    .bus_gnt_i   (bus_gnt_i),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o),
    .bus_req_o   (bus_req_o)
  );

  // {mem_first, req[11:0], expected channel[3:0]}
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 12'h401, 4'd0},
    {1'b0, 12'h021, 4'd5},
    {1'b0, 12'h801, 4'd11},
    {1'b1, 12'h408, 4'd10},
    {1'b1, 12'h401, 4'd0},
    {1'b1, 12'h402, 4'd1},
    {1'b1, 12'h804, 4'd2},
    {1'b0, 12'h210, 4'd9},
    {1'b0, 12'h410, 4'd10},
    {1'b0, 12'h410, 4'd4},
    {1'b1, 12'hFFF, 4'd3},
    {1'b0, 12'hFFF, 4'd6}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] oh(input int c);
    return N'(1) << c;
  endfunction

  // Full round: request, check winner, own the bus, release.
  task automatic round(input logic sel, input logic [N-1:0] rq, input int exp_ch, input string tag);
    @(negedge clk);
    mem_first_i = sel; req_i = rq; bus_gnt_i = 1'b0;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(exp_ch)), {tag, " R2/R3/R4/R5 winner"});
    chk(16'(bus_req_o), 16'd1, {tag, " R2 bus request"});
    @(negedge clk); bus_gnt_i = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_gnt_i = 1'b0; req_i = '0;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(exp_ch)), {tag, " R7 held"});
    @(negedge clk); xfer_done_i = 1'b1;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'd0, {tag, " R8 released"});
    chk(16'(bus_req_o), 16'd0, {tag, " R8 bus request low"});
    @(negedge clk); xfer_done_i = 1'b0;
  endtask

  initial begin
    #1;
    chk(16'(gnt_o), 16'd0, "R1 grant in reset");
    chk(16'(bus_req_o), 16'd0, "R1 bus request in reset");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < 12; i++) begin
      round(VEC[i][16], VEC[i][15:4], int'(VEC[i][3:0]), $sformatf("vec%0d", i));
    end

    // R9: idle, pointer holds at 7
    repeat (4) @(posedge clk);
    #1;
    chk(16'(gnt_o), 16'd0, "R9 idle grant");
    chk(16'(bus_req_o), 16'd0, "R9 idle bus request");
    round(1'b0, oh(0) | oh(7), 7, "R9 pointer held");

    // R6: grant follows requests before outer grant; pointer at 8
    @(negedge clk); mem_first_i = 1'b0; req_i = oh(1);
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(1)), "R6 wrap pick");
    @(negedge clk); req_i = oh(9); xfer_done_i = 1'b1;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(9)), "R6 re-evaluated, done ignored");
    @(negedge clk); req_i = '0; xfer_done_i = 1'b0;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'd0, "R6 drop to zero");
    chk(16'(bus_req_o), 16'd0, "R6 bus request drops");

    // R7/R10: select change during ownership; pointer still 8
    @(negedge clk); req_i = oh(2) | oh(10);
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(10)), "R5 pointer unchanged after R6");
    @(negedge clk); bus_gnt_i = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_gnt_i = 1'b0; mem_first_i = 1'b1; req_i = oh(2);
    repeat (2) @(posedge clk);
    #1;
    chk(16'(gnt_o), 16'(oh(10)), "R7 frozen across select change");
    @(negedge clk); xfer_done_i = 1'b1;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'd0, "R8 release");
    @(negedge clk); xfer_done_i = 1'b0; req_i = '0;
    // pointer 11, order now memory-first: pos11=ch9, wrap pos0=ch10, pos1=ch11
    round(1'b1, oh(2) | oh(11), 11, "R10 new order applied");

    // R1: reset during ownership
    @(negedge clk); mem_first_i = 1'b0; req_i = oh(4);
    @(posedge clk);
    @(negedge clk); bus_gnt_i = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_gnt_i = 1'b0; rst_ni = 1'b0; #1;
    chk(16'(gnt_o), 16'd0, "R1 async reset clears grant");
    @(negedge clk); rst_ni = 1'b1; req_i = '1;
    @(posedge clk); #1;
    chk(16'(gnt_o), 16'(oh(0)), "R1 pointer back at position 0");
    @(negedge clk); req_i = '0;
    @(posedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule